// File: doc/BRIEF.md
# Subclass-Ordered I/O Interruption Selector

This block keeps pending I/O interruption entries in eight independent last-in-first-out stacks, one for each interruption subclass. An entry is made of a 16-bit subchannel identifier, a 16-bit subchannel number, a 32-bit parameter and a 32-bit interruption word. The stack that receives a pushed entry is picked by the subclass field carried inside that entry's own interruption word.

When the controller raises a service request and the processor's I/O enable bit is set, the block walks the subclasses from 0 upward. For each non-empty stack it reads the subclass field of the top entry and looks up the matching enable bit in a 32-bit mask. The first stack that passes this test gives up its top entry, which appears on the delivery outputs one cycle later for exactly one cycle. A stack whose top entry is masked is passed over and left untouched. A pending output reports whether any stack still holds work, whether that work is enabled or not.

Top module: `io_irq_selector`

## Requirements
- R1: After reset no entry is held, `io_pending` is 0, and `dlv_vld`, `push_ovf` and `svc_err` are 0.
- R2: A push with `push_vld` high stores the entry in the stack selected by `push_word[4:2]`, and `io_pending` is 1 from the cycle after the push.
- R3: Within one subclass entries leave in reverse order of arrival: the most recent push is delivered first.
- R4: On a service request the lowest-numbered subclass that holds an enabled top entry is served, and at most one entry is delivered per request.
- R5: Subclass n is enabled when `en_mask[31-n]` is 1, with n read from bits [4:2] of the top entry's word. A stack whose top entry is disabled is skipped, keeps all of its entries, and keeps `io_pending` at 1.
- R6: A served request sets `dlv_vld` high in the following cycle only, with that entry on `dlv_id`, `dlv_nr`, `dlv_parm` and `dlv_word`.
- R7: `io_pending` stays 1 while any stack holds an entry and drops to 0 in the cycle after the last entry is delivered.
- R8: A service request while `io_mask_en` is 0 raises `svc_err` for one cycle in the following cycle, delivers nothing and changes no stack.
- R9: A service request with no enabled top entry delivers nothing and changes no stack.
- R10: A push into a stack already holding DEPTH entries (default 4) is dropped, `push_ovf` pulses high in the following cycle, and the stack's contents stay as they were.
- R11: When a push and a delivery hit the same cycle, the delivery gives the top entry held before that cycle and the pushed entry is stored afterwards; a full stack that is served in the same cycle accepts the push without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | Push an entry this cycle |
| push_id | input | 16 | Subchannel identifier of the pushed entry |
| push_nr | input | 16 | Subchannel number of the pushed entry |
| push_parm | input | 32 | Parameter of the pushed entry |
| push_word | input | 32 | Interruption word; bits [4:2] give the subclass |
| svc_req | input | 1 | Service request from the controller |
| io_mask_en | input | 1 | Processor I/O enable bit |
| en_mask | input | 32 | Subclass enable mask; bit 31-n enables subclass n |
| dlv_vld | output | 1 | Delivered entry valid (one cycle) |
| dlv_id | output | 16 | Delivered subchannel identifier |
| dlv_nr | output | 16 | Delivered subchannel number |
| dlv_parm | output | 32 | Delivered parameter |
| dlv_word | output | 32 | Delivered interruption word |
| io_pending | output | 1 | At least one stack holds an entry |
| push_ovf | output | 1 | Previous cycle's push was dropped on a full stack |
| svc_err | output | 1 | Previous cycle's request came with the I/O enable bit clear |

## Verification
A push and a delivery can land in the same cycle, and the sharp case is when both address the same subclass, above all when that stack is full. The bench drives pushes and service requests in the same cycle, both directed onto a full stack and at random across subclasses and masks. A bench model removes the served top entry before it applies the push, and so predicts the delivered entry, the absence of overflow and the later drain order, against which every output is compared.

// File: rtl/io_sel_pkg.sv
package io_sel_pkg;
  localparam int SC_W    = 3;
  localparam int SC_LSB  = 2;
  localparam int MASK_W  = 32;
  localparam int ID_W    = 16;
  localparam int NR_W    = 16;
  localparam int PARM_W  = 32;
  localparam int WORD_W  = 32;
  localparam int NUM_SC  = 1 << SC_W;

  typedef struct packed {
    logic [ID_W-1:0]   sch_id;
    logic [NR_W-1:0]   sch_nr;
    logic [PARM_W-1:0] parm;
    logic [WORD_W-1:0] word;
  } io_ent_t;

  function automatic logic [SC_W-1:0] word_sc(input logic [WORD_W-1:0] w);
    return w[SC_LSB +: SC_W];
  endfunction
endpackage

// File: rtl/io_rst_sync.sv
module io_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/io_sc_stack.sv
module io_sc_stack
  import io_sel_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push_i,
  input  logic    pop_i,
  input  io_ent_t din_i,
  output io_ent_t top_o,
  output logic    nonempty_o,
  output logic    drop_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_m1;
  io_ent_t          mem_q [DEPTH];
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, top_idx;
  logic             full, empty, pop_ok;

  always_comb begin
    full    = (cnt_q == FULL_CNT);
    empty   = (cnt_q == '0);
    cnt_m1  = cnt_q - 1'b1;
    top_idx = cnt_m1[IDX_W-1:0];
    pop_ok  = pop_i && !empty;
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    wr_idx  = '0;
    drop_o  = 1'b0;
    if (pop_ok && push_i) begin
      // served slot is reused by the incoming entry
      wr_en  = 1'b1;
      wr_idx = top_idx;
    end else if (pop_ok) begin
      cnt_d = cnt_m1;
    end else if (push_i) begin
      if (full) begin
        drop_o = 1'b1;
      end else begin
        wr_en  = 1'b1;
        wr_idx = cnt_q[IDX_W-1:0];
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= din_i;
  end

  assign top_o      = empty ? '0 : mem_q[top_idx];
  assign nonempty_o = !empty;
endmodule

// File: rtl/io_sc_arbiter.sv
module io_sc_arbiter
  import io_sel_pkg::*;
#(
  parameter int NSC = NUM_SC
) (
  input  logic [NSC-1:0]    nonempty_i,
  input  logic [WORD_W-1:0] top_word_i [NSC],
  input  logic [MASK_W-1:0] en_mask_i,
  output logic [NSC-1:0]    grant_o,
  output logic              hit_o
);
  logic [NSC-1:0] elig;

  for (genvar g = 0; g < NSC; g++) begin : g_elig
    logic [SC_W-1:0] sc;
    assign sc      = word_sc(top_word_i[g]);
    assign elig[g] = nonempty_i[g] && en_mask_i[(MASK_W - 1) - int'(sc)];
  end

  always_comb begin
    grant_o = '0;
    hit_o   = 1'b0;
    for (int i = 0; i < NSC; i++) begin
      if (elig[i] && !hit_o) begin
        grant_o[i] = 1'b1;
        hit_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/io_irq_selector.sv
module io_irq_selector
  import io_sel_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_vld,
  input  logic [ID_W-1:0]   push_id,
  input  logic [NR_W-1:0]   push_nr,
  input  logic [PARM_W-1:0] push_parm,
  input  logic [WORD_W-1:0] push_word,
  input  logic              svc_req,
  input  logic              io_mask_en,
  input  logic [MASK_W-1:0] en_mask,
  output logic              dlv_vld,
  output logic [ID_W-1:0]   dlv_id,
  output logic [NR_W-1:0]   dlv_nr,
  output logic [PARM_W-1:0] dlv_parm,
  output logic [WORD_W-1:0] dlv_word,
  output logic              io_pending,
  output logic              push_ovf,
  output logic              svc_err
);
  logic            rst_n_i;
  io_ent_t         push_ent;
  logic [SC_W-1:0] push_sc;
  logic [NUM_SC-1:0] st_push, st_pop, st_nonempty, st_drop, grant;
  io_ent_t         st_top [NUM_SC];
  logic [WORD_W-1:0] st_word [NUM_SC];
  logic            hit, svc_ok;
  io_ent_t         sel_ent;

  logic    dlv_vld_q, dlv_vld_d;
  io_ent_t dlv_ent_q;
  logic    dlv_ld;
  logic    ovf_q, ovf_d, err_q, err_d;

  io_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    push_ent = '{sch_id: push_id, sch_nr: push_nr, parm: push_parm, word: push_word};
    push_sc  = word_sc(push_word);
    svc_ok   = svc_req && io_mask_en;
  end

  for (genvar g = 0; g < NUM_SC; g++) begin : g_stk
    assign st_push[g] = push_vld && (push_sc == SC_W'(g));
    assign st_pop[g]  = svc_ok && grant[g];
    assign st_word[g] = st_top[g].word;

    io_sc_stack #(.DEPTH(DEPTH)) u_stk (
      .clk        (clk),
      .rst_n      (rst_n_i),
      .push_i     (st_push[g]),
      .pop_i      (st_pop[g]),
      .din_i      (push_ent),
      .top_o      (st_top[g]),
      .nonempty_o (st_nonempty[g]),
      .drop_o     (st_drop[g])
    );
  end

  io_sc_arbiter #(.NSC(NUM_SC)) u_arb (
    .nonempty_i (st_nonempty),
    .top_word_i (st_word),
    .en_mask_i  (en_mask),
    .grant_o    (grant),
    .hit_o      (hit)
  );

  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < NUM_SC; i++) begin
      if (grant[i]) sel_ent = sel_ent | st_top[i];
    end
    dlv_vld_d = svc_ok && hit;
    dlv_ld    = dlv_vld_d;
    err_d     = svc_req && !io_mask_en;
    ovf_d     = |st_drop;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dlv_vld_q <= 1'b0;
      ovf_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      dlv_vld_q <= dlv_vld_d;
      ovf_q     <= ovf_d;
      err_q     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    dlv_ent_q <= '0;
    else if (dlv_ld) dlv_ent_q <= sel_ent;
  end

  assign dlv_vld    = dlv_vld_q;
  assign dlv_id     = dlv_ent_q.sch_id;
  assign dlv_nr     = dlv_ent_q.sch_nr;
  assign dlv_parm   = dlv_ent_q.parm;
  assign dlv_word   = dlv_ent_q.word;
  assign io_pending = |st_nonempty;
  assign push_ovf   = ovf_q;
  assign svc_err    = err_q;
endmodule

// File: rtl/io_irq_selector_chk.sv
module io_irq_selector_chk
  import io_sel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              push_vld,
  input logic [ID_W-1:0]   push_id,
  input logic [NR_W-1:0]   push_nr,
  input logic [PARM_W-1:0] push_parm,
  input logic [WORD_W-1:0] push_word,
  input logic              svc_req,
  input logic              io_mask_en,
  input logic [MASK_W-1:0] en_mask,
  input logic              dlv_vld,
  input logic [ID_W-1:0]   dlv_id,
  input logic [NR_W-1:0]   dlv_nr,
  input logic [PARM_W-1:0] dlv_parm,
  input logic [WORD_W-1:0] dlv_word,
  input logic              io_pending,
  input logic              push_ovf,
  input logic              svc_err
);
  logic [MASK_W-1:0] dlv_bit;
  assign dlv_bit = {1'b1, {(MASK_W-1){1'b0}}} >> word_sc(dlv_word);

  p_dlv_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_vld |-> $past(svc_req && io_mask_en));

  p_err_after_bad_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_err |-> $past(svc_req && !io_mask_en));

  p_no_dlv_with_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dlv_vld && svc_err));

  p_dlv_needs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_vld |-> $past(io_pending));

  p_dlv_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_vld |-> (($past(en_mask) & dlv_bit) != '0));

  p_ovf_needs_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push_ovf |-> ($past(push_vld) && $past(io_pending)));
endmodule

bind io_irq_selector io_irq_selector_chk u_chk (.*);

// File: tb/sim_io_irq_selector.sv
`timescale 1ns/1ps
module sim_io_irq_selector;
  localparam int DEPTH = 4;
  localparam int NSC   = 8;

  logic        clk, rst_n;
  logic        push_vld;
  logic [15:0] push_id, push_nr;
  logic [31:0] push_parm, push_word;
  logic        svc_req, io_mask_en;
  logic [31:0] en_mask;
  logic        dlv_vld;
  logic [15:0] dlv_id, dlv_nr;
  logic [31:0] dlv_parm, dlv_word;
  logic        io_pending, push_ovf, svc_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [95:0] mdl [NSC][DEPTH];
  int          mcnt [NSC];

  io_irq_selector #(.DEPTH(DEPTH)) u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] mk(int sc);
    logic [31:0] a, b, c, d;
    a = $urandom(); b = $urandom(); c = $urandom(); d = $urandom();
    d[4:2] = sc[2:0];
    return {a[15:0], b[15:0], c, d};
  endfunction

  // Drive one cycle at a negedge, predict, then check at the next negedge.
  task automatic step(string tag, bit pv, logic [95:0] ent, bit rq, bit iom,
                      logic [31:0] msk);
    bit          e_dlv, e_err, e_ovf, e_pend;
    logic [95:0] e_ent;
    int          psc, top_sc;
    push_vld   = pv;
    {push_id, push_nr, push_parm, push_word} = ent;
    svc_req    = rq;
    io_mask_en = iom;
    en_mask    = msk;
    e_dlv = 0; e_err = 0; e_ovf = 0; e_ent = '0;
    if (rq && !iom) e_err = 1;
    if (rq && iom) begin
      for (int s = 0; s < NSC; s++) begin
        if (!e_dlv && mcnt[s] > 0) begin
          top_sc = int'(mdl[s][mcnt[s]-1][4:2]);
          if (msk[31 - top_sc]) begin
            e_dlv = 1;
            e_ent = mdl[s][mcnt[s]-1];
            mcnt[s]--;
          end
        end
      end
    end
    if (pv) begin
      psc = int'(ent[4:2]);
      if (mcnt[psc] < DEPTH) begin
        mdl[psc][mcnt[psc]] = ent;
        mcnt[psc]++;
      end else e_ovf = 1;
    end
    e_pend = 0;
    for (int s = 0; s < NSC; s++) if (mcnt[s] > 0) e_pend = 1;
    @(negedge clk);
    chk({tag, " dlv_vld"}, 96'(dlv_vld), 96'(e_dlv));
    if (e_dlv) chk({tag, " entry"}, {dlv_id, dlv_nr, dlv_parm, dlv_word}, e_ent);
    chk({tag, " svc_err"}, 96'(svc_err), 96'(e_err));
    chk({tag, " push_ovf"}, 96'(push_ovf), 96'(e_ovf));
    chk({tag, " io_pending"}, 96'(io_pending), 96'(e_pend));
  endtask

  task automatic idle(string tag);
    step(tag, 0, '0, 0, 1, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < NSC; s++) mcnt[s] = 0;
    rst_n = 0; push_vld = 0; push_id = 0; push_nr = 0; push_parm = 0;
    push_word = 0; svc_req = 0; io_mask_en = 0; en_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 io_pending", 96'(io_pending), 96'(0));
    chk("R1 dlv_vld", 96'(dlv_vld), 96'(0));
    chk("R1 push_ovf", 96'(push_ovf), 96'(0));
    chk("R1 svc_err", 96'(svc_err), 96'(0));

    // R2 and R3: three entries into subclass 2, drained in reverse order
    for (int k = 0; k < 3; k++) step("R2 push", 1, mk(2), 0, 1, '1);
    for (int k = 0; k < 3; k++) step("R3 lifo", 0, '0, 1, 1, '1);
    idle("R7 drained");

    // R4: subclass 5 and subclass 1 pending, subclass 1 wins
    step("R2 push sc5", 1, mk(5), 0, 1, '1);
    step("R2 push sc1", 1, mk(1), 0, 1, '1);
    step("R4 lowest first", 0, '0, 1, 1, '1);
    // R5: subclass 1 masked (bit 30 clear) -> subclass 5 served
    step("R2 push sc1", 1, mk(1), 0, 1, '1);
    step("R5 masked skip", 0, '0, 1, 1, 32'hBFFF_FFFF);
    step("R5 masked stays", 0, '0, 1, 1, 32'hBFFF_FFFF);
    // R8: request with I/O enable clear
    step("R8 bad req", 0, '0, 1, 0, '1);
    // R9: nothing enabled
    step("R9 none enabled", 0, '0, 1, 1, 32'h0);
    step("R7 last", 0, '0, 1, 1, '1);
    idle("R7 empty");

    // R10: overflow on subclass 3
    for (int k = 0; k < DEPTH; k++) step("R2 fill", 1, mk(3), 0, 1, '1);
    step("R10 overflow", 1, mk(3), 0, 1, '1);
    // R11: full stack served and pushed in the same cycle
    step("R11 push+pop full", 1, mk(3), 1, 1, '1);
    step("R11 push+pop other", 1, mk(6), 1, 1, '1);
    for (int k = 0; k < DEPTH + 2; k++) step("R10 drain", 0, '0, 1, 1, '1);
    idle("R7 empty2");

    // Random phase: R4 R5 R6 R8 R9 R10 R11
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r, msk;
      r   = $urandom();
      msk = (r[7:6] == 2'b00) ? $urandom() : 32'hFFFF_FFFF;
      step("R6 random", r[0] | r[1], mk(int'(r[10:8])), r[2] & (r[3] | r[4]),
           r[5:4] != 2'b00, msk);
    end
    for (int k = 0; k < NSC * DEPTH + 2; k++) step("R7 final drain", 0, '0, 1, 1, '1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule